// File: doc/BRIEF.md
# Saturating Output Summing Junction

This block builds the final sample sent to a DAC. Each cycle it adds a signed offset stream to the signed in-phase output of the channel's own up-converter. The in-phase term is added only when the in-phase enable is set. A paired neighbouring channel also supplies a quadrature sample, which the block accepts and then discards. The sum is formed two bits wider than a sample, so it cannot wrap. It is then clamped between a lower and an upper signed limit, both programmable, and registered.

The same clamp logic, with its own limit pair, sits on the I and Q samples that feed the up-converter. Both lanes share one pair of limits. Software programs the limits and the enable word through a small write-only configuration port: an address, a data word and a write strobe. A write takes effect on the sample presented in the following cycle.

Top module: `sjx_output_junction`

## Requirements
- R1: While reset is asserted, and on release, all three sample outputs read 0. After reset the in-phase enable is 1, the quadrature enable is 0, and both limit pairs are lower -32767 and upper +32767.
- R2: `dac_out` equals the offset input plus, when the in-phase enable is 1, the own in-phase input, clamped to the output limits.
- R3: The sum is formed without wrap-around. Two full-scale positive inputs give the upper limit, and two full-scale negative inputs give the lower limit.
- R4: A write to address 2 loads the enable word: bit 0 is the in-phase enable and bit 1 is the quadrature enable. With bit 0 clear, the own in-phase input does not contribute.
- R5: The buddy quadrature input never contributes to `dac_out`, whatever the quadrature enable holds.
- R6: A write to address 4 sets the output lower limit and a write to address 5 sets the output upper limit. Each limit is taken from bits 15:0 of the write data as a signed value, and upper data bits are ignored.
- R7: A write to address 6 sets the up-converter lower limit and a write to address 7 sets its upper limit. One pair clamps both `uc_i_out` and `uc_q_out`.
- R8: When a programmed lower limit exceeds its upper limit, the clamped output equals the upper limit.
- R9: Writes to addresses 0, 1 and 3 change no limit and no enable.
- R10: Every output shows its result exactly one clock after the inputs are presented. A new write applies from the sample of the next cycle.
- R11: With the default limits, an input or sum of -32768 is clamped to -32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data; limits use bits 15:0 |
| offset_in | input | 16 | Signed offset sample |
| own_i_in | input | 16 | Signed in-phase up-converter output of this channel |
| buddy_q_in | input | 16 | Signed quadrature sample from the paired channel (discarded) |
| uc_i_in | input | 16 | Signed I sample entering the up-converter |
| uc_q_in | input | 16 | Signed Q sample entering the up-converter |
| dac_out | output | 16 | Registered, clamped DAC sample |
| uc_i_out | output | 16 | Registered, clamped up-converter I sample |
| uc_q_out | output | 16 | Registered, clamped up-converter Q sample |

## Verification
Directed sums at both full-scale corners show the difference between a wide sum and a wrapping one, and between the default limits and a two's-complement floor. Narrow asymmetric windows, one of them inverted, show that the lower and upper limits do not trade places, and that the two limit pairs stay independent of each other. The enable is toggled while the buddy sample is large and nonzero. Writes aimed at the unused addresses, or carrying junk in their upper data bits, confirm that only the intended fields change. Random samples weighted toward the extremes are then mixed with random writes, so that clamping, pass-through and limit changes in mid-stream all occur against a model kept in the bench.

// File: rtl/sjx_pkg.sv
package sjx_pkg;
  localparam int SAMPLE_W = 16;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;

  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd2;
  localparam logic [ADDR_W-1:0] A_OUT_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_OUT_HI = 3'd5;
  localparam logic [ADDR_W-1:0] A_UC_LO  = 3'd6;
  localparam logic [ADDR_W-1:0] A_UC_HI  = 3'd7;

  localparam int EN_I_BIT = 0;
  localparam int EN_Q_BIT = 1;

  typedef enum logic [1:0] {
    CL_PASS = 2'd0,
    CL_LO   = 2'd1,
    CL_HI   = 2'd2
  } clamp_sel_e;
endpackage

// File: rtl/sjx_rst_sync.sv
module sjx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sjx_cfg_regs.sv
module sjx_cfg_regs
  import sjx_pkg::*;
#(
  parameter int W    = SAMPLE_W,
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic signed [W-1:0] out_lo,
  output logic signed [W-1:0] out_hi,
  output logic signed [W-1:0] uc_lo,
  output logic signed [W-1:0] uc_hi,
  output logic                i_en,
  output logic                q_en
);
  localparam logic signed [W-1:0] FS_POS = W'(2 ** (W - 1) - 1);
  localparam logic signed [W-1:0] FS_NEG = -FS_POS;

  logic signed [W-1:0] out_lo_q, out_hi_q, uc_lo_q, uc_hi_q;
  logic signed [W-1:0] out_lo_d, out_hi_d, uc_lo_d, uc_hi_d;
  logic                i_en_q, q_en_q, i_en_d, q_en_d;
  logic                ld_en, ld_olo, ld_ohi, ld_ulo, ld_uhi;
  logic [DW-1:0]       wdata_unused;

  // decode: one clock enable per register
  always_comb begin
    ld_en  = we && (addr == A_ENABLE);
    ld_olo = we && (addr == A_OUT_LO);
    ld_ohi = we && (addr == A_OUT_HI);
    ld_ulo = we && (addr == A_UC_LO);
    ld_uhi = we && (addr == A_UC_HI);
  end

  // next-state values
  always_comb begin
    out_lo_d = $signed(wdata[W-1:0]);
    out_hi_d = $signed(wdata[W-1:0]);
    uc_lo_d  = $signed(wdata[W-1:0]);
    uc_hi_d  = $signed(wdata[W-1:0]);
    i_en_d   = wdata[EN_I_BIT];
    q_en_d   = wdata[EN_Q_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_lo_q <= FS_NEG;
      out_hi_q <= FS_POS;
      uc_lo_q  <= FS_NEG;
      uc_hi_q  <= FS_POS;
      i_en_q   <= 1'b1;
      q_en_q   <= 1'b0;
    end else begin
      if (ld_olo) out_lo_q <= out_lo_d;
      if (ld_ohi) out_hi_q <= out_hi_d;
      if (ld_ulo) uc_lo_q  <= uc_lo_d;
      if (ld_uhi) uc_hi_q  <= uc_hi_d;
      if (ld_en) begin
        i_en_q <= i_en_d;
        q_en_q <= q_en_d;
      end
    end
  end

  assign wdata_unused = wdata;

  assign out_lo = out_lo_q;
  assign out_hi = out_hi_q;
  assign uc_lo  = uc_lo_q;
  assign uc_hi  = uc_hi_q;
  assign i_en   = i_en_q;
  assign q_en   = q_en_q;
endmodule

// File: rtl/sjx_sat_stage.sv
module sjx_sat_stage
  import sjx_pkg::*;
#(
  parameter int W    = SAMPLE_W,
  parameter int IN_W = SAMPLE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic signed [IN_W-1:0] val_in,
  input  logic signed [W-1:0]    lo,
  input  logic signed [W-1:0]    hi,
  output logic signed [W-1:0]    val_out
);
  logic signed [IN_W-1:0] lo_x, hi_x;
  clamp_sel_e             sel;
  logic signed [W-1:0]    val_d, val_q;

  assign lo_x = IN_W'(lo);
  assign hi_x = IN_W'(hi);

  // upper limit wins when the window is inverted
  always_comb begin
    if (lo_x > hi_x)        sel = CL_HI;
    else if (val_in > hi_x) sel = CL_HI;
    else if (val_in < lo_x) sel = CL_LO;
    else                    sel = CL_PASS;
  end

  always_comb begin
    case (sel)
      CL_HI:   val_d = hi;
      CL_LO:   val_d = lo;
      default: val_d = val_in[W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  val_q <= '0;
    else if (en) val_q <= val_d;
  end

  assign val_out = val_q;
endmodule

// File: rtl/sjx_output_junction.sv
module sjx_output_junction
  import sjx_pkg::*;
#(
  parameter int W  = SAMPLE_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [DW-1:0]       cfg_wdata,
  input  logic signed [W-1:0] offset_in,
  input  logic signed [W-1:0] own_i_in,
  input  logic signed [W-1:0] buddy_q_in,
  input  logic signed [W-1:0] uc_i_in,
  input  logic signed [W-1:0] uc_q_in,
  output logic signed [W-1:0] dac_out,
  output logic signed [W-1:0] uc_i_out,
  output logic signed [W-1:0] uc_q_out
);
  localparam int SUM_W  = W + 2;
  localparam int LANES  = 2;

  logic                rst_sync_n;
  logic signed [W-1:0] out_lo, out_hi, uc_lo, uc_hi;
  logic                i_en, q_en;
  logic signed [SUM_W-1:0] sum_w, own_term;
  logic [W:0]          buddy_unused;
  logic signed [W-1:0] lane_in  [LANES];
  logic signed [W-1:0] lane_out [LANES];
  logic                stage_en;

  sjx_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  sjx_cfg_regs #(.W(W), .AW(AW), .DW(DW)) u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .out_lo(out_lo),
    .out_hi(out_hi),
    .uc_lo (uc_lo),
    .uc_hi (uc_hi),
    .i_en  (i_en),
    .q_en  (q_en)
  );

  assign stage_en = 1'b1;

  // wide sum; the quadrature sample of the paired channel is discarded
  always_comb begin
    own_term = i_en ? SUM_W'(own_i_in) : '0;
    sum_w    = SUM_W'(offset_in) + own_term;
  end
  assign buddy_unused = {q_en, buddy_q_in};

  sjx_sat_stage #(.W(W), .IN_W(SUM_W)) u_out_sat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (stage_en),
    .val_in (sum_w),
    .lo     (out_lo),
    .hi     (out_hi),
    .val_out(dac_out)
  );

  assign lane_in[0] = uc_i_in;
  assign lane_in[1] = uc_q_in;

  for (genvar g = 0; g < LANES; g++) begin : g_uc_lane
    sjx_sat_stage #(.W(W), .IN_W(W)) u_uc_sat (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .en     (stage_en),
      .val_in (lane_in[g]),
      .lo     (uc_lo),
      .hi     (uc_hi),
      .val_out(lane_out[g])
    );
  end

  assign uc_i_out = lane_out[0];
  assign uc_q_out = lane_out[1];
endmodule

// File: rtl/sjx_junction_checker.sv
module sjx_junction_checker #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_ni,
  input logic signed [W-1:0] dac_out,
  input logic signed [W-1:0] uc_i_out,
  input logic signed [W-1:0] uc_q_out,
  input logic signed [W-1:0] out_lo,
  input logic signed [W-1:0] out_hi,
  input logic signed [W-1:0] uc_lo,
  input logic signed [W-1:0] uc_hi,
  input logic                i_en,
  input logic signed [W-1:0] offset_in
);
  // R6: output stays inside a well-ordered window
  a_r6_out_in_range: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(out_lo) <= $past(out_hi)) |->
      (dac_out >= $past(out_lo) && dac_out <= $past(out_hi)));

  // R8: inverted window yields the upper limit
  a_r8_inverted_gives_hi: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(out_lo) > $past(out_hi)) |-> (dac_out == $past(out_hi)));

  // R7: both up-converter lanes bounded by the shared pair
  a_r7_uc_i_in_range: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(uc_lo) <= $past(uc_hi)) |->
      (uc_i_out >= $past(uc_lo) && uc_i_out <= $past(uc_hi)));

  a_r7_uc_q_in_range: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(uc_lo) <= $past(uc_hi)) |->
      (uc_q_out >= $past(uc_lo) && uc_q_out <= $past(uc_hi)));

  // R4: with the in-phase term gated off, an in-window offset passes unchanged
  a_r4_gated_passthrough: assert property (@(posedge clk) disable iff (!rst_ni)
    (!$past(i_en) && $past(offset_in) >= $past(out_lo) &&
     $past(offset_in) <= $past(out_hi)) |-> (dac_out == $past(offset_in)));
endmodule

bind sjx_output_junction sjx_junction_checker #(.W(W)) u_junction_chk (
  .clk      (clk),
  .rst_ni   (rst_sync_n),
  .dac_out  (dac_out),
  .uc_i_out (uc_i_out),
  .uc_q_out (uc_q_out),
  .out_lo   (out_lo),
  .out_hi   (out_hi),
  .uc_lo    (uc_lo),
  .uc_hi    (uc_hi),
  .i_en     (i_en),
  .offset_in(offset_in)
);

// File: tb/tb_sjx_output_junction.sv
module tb_sjx_output_junction;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cfg_we = 1'b0;
  logic [2:0]         cfg_addr = '0;
  logic [31:0]        cfg_wdata = '0;
  logic signed [15:0] offset_in = '0, own_i_in = '0, buddy_q_in = '0;
  logic signed [15:0] uc_i_in = '0, uc_q_in = '0;
  logic signed [15:0] dac_out, uc_i_out, uc_q_out;

  int total = 0;
  int bad   = 0;

  // bench model of configuration
  int m_olo = -32767, m_ohi = 32767, m_ulo = -32767, m_uhi = 32767;
  bit m_ien = 1'b1;

  int    exp_dac, exp_ui, exp_uq;
  string exp_tag;
  bit    have_exp = 1'b0;

  always #10 clk = ~clk;

  sjx_output_junction dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .offset_in(offset_in), .own_i_in(own_i_in),
    .buddy_q_in(buddy_q_in), .uc_i_in(uc_i_in), .uc_q_in(uc_q_in),
    .dac_out(dac_out), .uc_i_out(uc_i_out), .uc_q_out(uc_q_out)
  );

  function automatic int clampf(int v, int lo, int hi);
    if (lo > hi) return hi;
    if (v > hi)  return hi;
    if (v < lo)  return lo;
    return v;
  endfunction

  task automatic check(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // one cycle: check the previous result, then present new stimulus
  task automatic apply(bit we, logic [2:0] a, logic [31:0] d,
                       int off, int own, int bq, int ui, int uq, string tag);
    int sum;
    @(negedge clk);
    if (have_exp) begin
      check(exp_tag, int'(dac_out), exp_dac);
      check("R7", int'(uc_i_out), exp_ui);
      check("R7", int'(uc_q_out), exp_uq);
    end
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    offset_in = 16'(off); own_i_in = 16'(own); buddy_q_in = 16'(bq);
    uc_i_in = 16'(ui); uc_q_in = 16'(uq);
    sum = off + (m_ien ? own : 0);
    #1;
    if (have_exp) check("R10", int'(dac_out), exp_dac);
    exp_dac = clampf(sum, m_olo, m_ohi);
    exp_ui  = clampf(ui, m_ulo, m_uhi);
    exp_uq  = clampf(uq, m_ulo, m_uhi);
    exp_tag = tag;
    have_exp = 1'b1;
    if (we) begin
      case (a)
        3'd2: m_ien = d[0];
        3'd4: m_olo = int'($signed(d[15:0]));
        3'd5: m_ohi = int'($signed(d[15:0]));
        3'd6: m_ulo = int'($signed(d[15:0]));
        3'd7: m_uhi = int'($signed(d[15:0]));
        default: ;
      endcase
    end
  endtask

  task automatic idle_sample(int off, int own, int bq, int ui, int uq, string tag);
    apply(1'b0, 3'd0, 32'd0, off, own, bq, ui, uq, tag);
  endtask

  function automatic int rnd_sample();
    case ($urandom % 4)
      0:       return 32767;
      1:       return -32768;
      2:       return int'($signed(16'($urandom)));
      default: return int'($urandom % 4001) - 2000;
    endcase
  endfunction

  function automatic logic [15:0] rnd_limit();
    case ($urandom % 4)
      0:       return 16'(32767);
      1:       return 16'(-32767);
      2:       return 16'($urandom);
      default: return 16'(int'($urandom % 8001) - 4000);
    endcase
  endfunction

  function automatic string pick_tag(int off, int own);
    int s;
    s = off + (m_ien ? own : 0);
    if (m_olo > m_ohi)             return "R8";
    if (s > 32767 || s < -32768)   return "R3";
    if (s > m_ohi || s < m_olo)    return "R6";
    if (!m_ien)                    return "R4";
    return "R2";
  endfunction

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5521));
    repeat (4) @(negedge clk);
    // R1: outputs held at zero in reset
    check("R1", int'(dac_out), 0);
    check("R1", int'(uc_i_out), 0);
    check("R1", int'(uc_q_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", int'(dac_out), 0);

    // full-scale corners against default limits
    idle_sample(32767, 32767, 0, 32767, 32767, "R3");
    idle_sample(-32768, -32768, 0, -32768, -32768, "R11");
    idle_sample(-32768, 0, 0, 5, -32768, "R11");
    idle_sample(1000, -300, 0, 7, -7, "R2");
    idle_sample(-1234, 4321, 0, 0, 0, "R2");

    // enable word
    apply(1'b1, 3'd2, 32'h0000_0000, 5, 9, 0, 0, 0, "R10");
    idle_sample(5, 9, 0, 0, 0, "R4");
    idle_sample(-300, 32767, 0, 0, 0, "R4");
    apply(1'b1, 3'd2, 32'h0000_0003, 5, 9, 0, 0, 0, "R4");
    idle_sample(100, 1, 12345, 0, 0, "R5");
    idle_sample(100, 1, -32768, 0, 0, "R5");
    apply(1'b1, 3'd2, 32'h0000_0002, 7, 2, 30000, 0, 0, "R5");
    idle_sample(7, 2, 30000, 0, 0, "R5");
    apply(1'b1, 3'd2, 32'hFFFF_FFF1, 7, 2, 30000, 0, 0, "R5");

    // output limits from the low half only
    apply(1'b1, 3'd4, 32'hABCD_FF00, 0, 0, 0, 0, 0, "R6");
    apply(1'b1, 3'd5, 32'h1234_0100, 0, 0, 0, 0, 0, "R6");
    idle_sample(1000, 0, 0, 0, 0, "R6");
    idle_sample(-1000, 0, 0, 0, 0, "R6");
    idle_sample(200, 50, 0, 0, 0, "R6");

    // up-converter limits, shared by I and Q
    apply(1'b1, 3'd6, 32'h0000_FF9C, 0, 0, 0, 0, 0, "R7");
    apply(1'b1, 3'd7, 32'h7777_0032, 0, 0, 0, 0, 0, "R7");
    idle_sample(0, 0, 0, 200, -500, "R7");
    idle_sample(0, 0, 0, -500, 200, "R7");
    idle_sample(10, 0, 0, 12, -12, "R7");

    // inverted window
    apply(1'b1, 3'd4, 32'h0000_012C, 0, 0, 0, 0, 0, "R6");
    idle_sample(0, 0, 0, 0, 0, "R8");
    idle_sample(-5000, 0, 0, 0, 0, "R8");
    idle_sample(5000, 0, 0, 0, 0, "R8");
    apply(1'b1, 3'd6, 32'h0000_0064, 0, 0, 0, -300, 300, "R8");
    idle_sample(0, 0, 0, -300, 300, "R8");

    // ignored addresses
    apply(1'b1, 3'd0, 32'hFFFF_8001, 9, 1, 0, 0, 0, "R9");
    apply(1'b1, 3'd1, 32'hFFFF_FFFE, 9, 1, 0, 0, 0, "R9");
    apply(1'b1, 3'd3, 32'h0000_0000, 9, 1, 0, 0, 0, "R9");
    idle_sample(-9000, 1, 0, -300, 300, "R9");
    idle_sample(9000, 1, 0, -300, 300, "R9");

    // restore defaults
    apply(1'b1, 3'd4, 32'h0000_8001, 0, 0, 0, 0, 0, "R8");
    apply(1'b1, 3'd5, 32'h0000_7FFF, 0, 0, 0, 0, 0, "R2");
    apply(1'b1, 3'd6, 32'h0000_8001, 0, 0, 0, 0, 0, "R2");
    apply(1'b1, 3'd7, 32'h0000_7FFF, 0, 0, 0, 0, 0, "R2");

    // random mix
    for (int k = 0; k < 600; k++) begin
      int off, own, bq, ui, uq;
      bit we;
      logic [2:0] a;
      logic [31:0] d;
      off = rnd_sample(); own = rnd_sample(); bq = rnd_sample();
      ui = rnd_sample(); uq = rnd_sample();
      we = ($urandom % 8) < 2;
      a = 3'($urandom);
      d = {16'($urandom), rnd_limit()};
      if (a == 3'd2) d[0] = ($urandom % 4) != 0;
      apply(we, a, d, off, own, bq, ui, uq, pick_tag(off, own));
    end
    idle_sample(0, 0, 0, 0, 0, "R2");
    @(negedge clk);
    check(exp_tag, int'(dac_out), exp_dac);
    check("R7", int'(uc_i_out), exp_ui);
    check("R7", int'(uc_q_out), exp_uq);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule